// File: doc/BRIEF.md
# Shared-Pin Port Controller

This block manages a group of general-purpose port pins that share their pads with other functions. Six bidirectional ports each have a direction bit and an output data bit. Two further pins are input-only: each can act as a plain input or be handed to one of two frequency counters. One of the bidirectional ports can instead carry a PLL unlock flag.

Pad drive is open-drain. For each port the block either pulls the pad low or releases it. Outputs are never driven high. Software writes three registers through strobe-and-data pairs:

- direction
- output data
- pin function

Software reads back the pad levels through a multi-flop synchronizer. A pin that is routed to a counter reads back as 0.

Top module: `pinshare_ctrl`

## Requirements
- R1: After reset, direction is 0b001000 (port 3 is the only output), output data is all ones, and the function register is 0. As a result no pad is driven low, both counter outputs are 0 and `rd_data` is 0. While reset is asserted, `pad_drv_lo` is 0.
- R2: `dir_wdata` bit i sets the direction of port i: 1 makes it an output and 0 makes it an input.
- R3: A port whose direction bit is 0 is never driven low, whatever its output data bit holds. The exception is the takeover case in R5.
- R4: On an output port, a data bit of 0 drives the pad low (`pad_drv_lo[i]=1`). A data bit of 1 releases the pad (`pad_drv_lo[i]=0`).
- R5: Function bit 2 set to 1 hands port 5 to the unlock flag. In that case `pad_drv_lo[5]` equals `lock_lost`, regardless of the direction and data bits of port 5.
- R6: Function bit 0 set to 1 routes aux pin 0 (`pad_aux_in[0]`) to `hctr_out` and forces `rd_data[6]` to 0. Set to 0, it holds `hctr_out` at 0 and `rd_data[6]` shows the synchronized pin.
- R7: Function bit 1 set to 1 routes aux pin 1 to `lctr_out` and forces `rd_data[7]` to 0. Set to 0, it holds `lctr_out` at 0 and `rd_data[7]` shows the synchronized pin.
- R8: `rd_data[5:0]` shows `pad_io_in`, and the unmasked bits of `rd_data[7:6]` show `pad_aux_in`. A pad change appears exactly two rising clock edges later and not after one.
- R9: A register changes only on a rising edge with its write strobe high. Its new value acts on `pad_drv_lo` in the cycle after that edge. Data presented with the strobe low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_wr | input | 1 | Direction register write strobe |
| dir_wdata | input | 6 | Direction value, 1 = output |
| dat_wr | input | 1 | Output data register write strobe |
| dat_wdata | input | 6 | Output data, 0 = drive low, 1 = release |
| fn_wr | input | 1 | Function register write strobe |
| fn_wdata | input | 3 | Bit 0: aux0 to high counter. Bit 1: aux1 to low counter. Bit 2: port 5 carries unlock |
| lock_lost | input | 1 | PLL unlock flag, 1 = unlocked |
| pad_io_in | input | 6 | Pad levels of the bidirectional ports |
| pad_aux_in | input | 2 | Pad levels of the input-only pins |
| pad_drv_lo | output | 6 | 1 = pull pad low, 0 = release |
| hctr_out | output | 1 | Aux pin 0 routed to the high-frequency counter |
| lctr_out | output | 1 | Aux pin 1 routed to the low-frequency counter |
| rd_data | output | 8 | Synchronized pad readback, counter-routed pins masked |

## Verification
The bench sweeps every combination of direction and data, with port 5 takeover off and on and with both unlock levels. Each pad's drive is checked against the open-drain rule bit by bit. A design that inverted the data sense, drove input ports, or let the data bit of port 5 leak through during takeover would miss on individual bits. The reset direction is probed by writing all-zero data and expecting only port 3 to pull low; a wrong reset pattern would pull other pads or none. Readback is swept over all pad patterns and all counter-routing settings. The bench looks one edge early to catch a synchronizer one stage too short, and checks the masking of counter-owned pins and the gating of the counter outputs.

// File: rtl/pinshare_pkg.sv
package pinshare_pkg;
   // Bit positions in the function register
   localparam int FN_HI_CTR = 0;   // aux pin 0 to high-frequency counter
   localparam int FN_LO_CTR = 1;   // aux pin 1 to low-frequency counter
   localparam int FN_UL_OUT = 2;   // unlock flag takes over the shared port
   localparam int FN_W      = 3;
   localparam int AUX_W     = 2;   // input-only pins
endpackage

// File: rtl/pinshare_reg.sv
module pinshare_reg #(
   parameter int          W   = 6,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/pinshare_sync.sv
module pinshare_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[0] <= '0;
               else        st[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[s] <= '0;
               else        st[s] <= st[s-1];
            end
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/pinshare_drive.sv
module pinshare_drive #(
   parameter int N       = 6,
   parameter int UL_PORT = 5
) (
   input  logic [N-1:0] dir,
   input  logic [N-1:0] dat,
   input  logic         ul_en,
   input  logic         lock_lost,
   output logic [N-1:0] drv_lo
);
   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_pin
         if (i == UL_PORT) begin : g_shared
            assign drv_lo[i] = ul_en ? lock_lost : (dir[i] & ~dat[i]);
         end else begin : g_plain
            assign drv_lo[i] = dir[i] & ~dat[i];
         end
      end
   endgenerate
endmodule

// File: rtl/pinshare_ctrl.sv
module pinshare_ctrl
   import pinshare_pkg::*;
#(
   parameter int               N_IO        = 6,
   parameter int               UL_PORT     = 5,
   parameter int               SYNC_STAGES = 2,
   parameter logic [N_IO-1:0]  DIR_RST     = 6'b001000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dir_wr,
   input  logic [N_IO-1:0]       dir_wdata,
   input  logic                  dat_wr,
   input  logic [N_IO-1:0]       dat_wdata,
   input  logic                  fn_wr,
   input  logic [FN_W-1:0]       fn_wdata,
   input  logic                  lock_lost,
   input  logic [N_IO-1:0]       pad_io_in,
   input  logic [AUX_W-1:0]      pad_aux_in,
   output logic [N_IO-1:0]       pad_drv_lo,
   output logic                  hctr_out,
   output logic                  lctr_out,
   output logic [N_IO+AUX_W-1:0] rd_data
);
   localparam int RD_W = N_IO + AUX_W;

   generate
      if (N_IO < 1)              begin : g_bad_n    $error("N_IO must be at least 1"); end
      if (UL_PORT >= N_IO)       begin : g_bad_ul   $error("UL_PORT outside port range"); end
      if (SYNC_STAGES < 2)       begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic [N_IO-1:0]  dir_q;
   logic [N_IO-1:0]  dat_q;
   logic [FN_W-1:0]  fn_q;
   logic [RD_W-1:0]  sync_q;
   logic [RD_W-1:0]  rd_mask;

   pinshare_reg #(.W(N_IO), .RST(DIR_RST)) u_dir (
      .clk(clk), .rst_n(rst_n), .we(dir_wr), .d(dir_wdata), .q(dir_q));

   pinshare_reg #(.W(N_IO), .RST({N_IO{1'b1}})) u_dat (
      .clk(clk), .rst_n(rst_n), .we(dat_wr), .d(dat_wdata), .q(dat_q));

   pinshare_reg #(.W(FN_W), .RST({FN_W{1'b0}})) u_fn (
      .clk(clk), .rst_n(rst_n), .we(fn_wr), .d(fn_wdata), .q(fn_q));

   pinshare_drive #(.N(N_IO), .UL_PORT(UL_PORT)) u_drv (
      .dir(dir_q), .dat(dat_q), .ul_en(fn_q[FN_UL_OUT]),
      .lock_lost(lock_lost), .drv_lo(pad_drv_lo));

   pinshare_sync #(.W(RD_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({pad_aux_in, pad_io_in}), .q(sync_q));

   // Counter-owned aux pins read back as zero
   always_comb begin
      rd_mask = '1;
      rd_mask[N_IO + 0] = ~fn_q[FN_HI_CTR];
      rd_mask[N_IO + 1] = ~fn_q[FN_LO_CTR];
   end

   assign rd_data  = sync_q & rd_mask;
   assign hctr_out = fn_q[FN_HI_CTR] & pad_aux_in[0];
   assign lctr_out = fn_q[FN_LO_CTR] & pad_aux_in[1];
endmodule

// File: rtl/pinshare_chk.sv
module pinshare_chk
   import pinshare_pkg::*;
#(
   parameter int N_IO    = 6,
   parameter int UL_PORT = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  dir_wr,
   input logic [N_IO-1:0]       dir_q,
   input logic [FN_W-1:0]       fn_q,
   input logic                  lock_lost,
   input logic [N_IO-1:0]       pad_drv_lo,
   input logic                  hctr_out,
   input logic                  lctr_out,
   input logic [N_IO+AUX_W-1:0] rd_data
);
   logic [N_IO-1:0] ul_mask;
   assign ul_mask = fn_q[FN_UL_OUT] ? (N_IO'(1) << UL_PORT) : '0;

   // R3
   input_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_drv_lo & ~dir_q & ~ul_mask) == '0));

   // R5
   unlock_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fn_q[FN_UL_OUT] |-> (pad_drv_lo[UL_PORT] == lock_lost));

   // R6
   hi_ctr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fn_q[FN_HI_CTR] ? (rd_data[N_IO] == 1'b0) : (hctr_out == 1'b0));

   // R7
   lo_ctr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fn_q[FN_LO_CTR] ? (rd_data[N_IO+1] == 1'b0) : (lctr_out == 1'b0));

   // R9
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_wr |=> $stable(dir_q));
endmodule

bind pinshare_ctrl pinshare_chk #(.N_IO(N_IO), .UL_PORT(UL_PORT)) u_chk (
   .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dir_q(dir_q), .fn_q(fn_q),
   .lock_lost(lock_lost), .pad_drv_lo(pad_drv_lo), .hctr_out(hctr_out),
   .lctr_out(lctr_out), .rd_data(rd_data));

// File: tb/sim_pinshare_ctrl.sv
module sim_pinshare_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dir_wr = 1'b0, dat_wr = 1'b0, fn_wr = 1'b0;
   logic [5:0] dir_wdata = '0, dat_wdata = '0;
   logic [2:0] fn_wdata = '0;
   logic       lock_lost = 1'b0;
   logic [5:0] pad_io_in = '0;
   logic [1:0] pad_aux_in = '0;
   logic [5:0] pad_drv_lo;
   logic       hctr_out, lctr_out;
   logic [7:0] rd_data;

   int n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pinshare_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dir_wdata(dir_wdata),
      .dat_wr(dat_wr), .dat_wdata(dat_wdata), .fn_wr(fn_wr), .fn_wdata(fn_wdata),
      .lock_lost(lock_lost), .pad_io_in(pad_io_in), .pad_aux_in(pad_aux_in),
      .pad_drv_lo(pad_drv_lo), .hctr_out(hctr_out), .lctr_out(lctr_out),
      .rd_data(rd_data));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_dir(input logic [5:0] v);
      @(negedge clk); dir_wr = 1'b1; dir_wdata = v;
      @(negedge clk); dir_wr = 1'b0;
   endtask
   task automatic wr_dat(input logic [5:0] v);
      @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
      @(negedge clk); dat_wr = 1'b0;
   endtask
   task automatic wr_fn(input logic [2:0] v);
      @(negedge clk); fn_wr = 1'b1; fn_wdata = v;
      @(negedge clk); fn_wr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_run++; n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] prev_raw;
      logic [7:0] exp_rd;
      logic [5:0] e;

      // R1: state while reset is held
      pad_io_in = 6'h3F; pad_aux_in = 2'b11;
      repeat (3) @(negedge clk);
      check(pad_drv_lo == 6'h00, "R1 drive in reset", pad_drv_lo, 0);
      check(rd_data == 8'h00, "R1 readback in reset", rd_data, 0);
      check(hctr_out == 1'b0 && lctr_out == 1'b0, "R1 counters in reset",
            {hctr_out, lctr_out}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pad_drv_lo == 6'h00, "R1 data resets to ones", pad_drv_lo, 0);
      wr_dat(6'h00);
      check(pad_drv_lo == 6'b001000, "R1 reset direction", pad_drv_lo, 6'b001000);

      // R2: direction bit selects output
      wr_dir(6'b000001);
      check(pad_drv_lo == 6'b000001, "R2 port0 output", pad_drv_lo, 1);
      wr_dir(6'b000000);
      check(pad_drv_lo == 6'b000000, "R2 port0 input", pad_drv_lo, 0);

      // R9: data presented without strobe is ignored
      wr_dir(6'h3F);
      @(negedge clk); dat_wdata = 6'h3F; dir_wdata = 6'h00; fn_wdata = 3'b100;
      lock_lost = 1'b0;
      @(negedge clk); @(negedge clk);
      check(pad_drv_lo == 6'h3F, "R9 no strobe no change", pad_drv_lo, 6'h3F);

      // R3 R4 R5: exhaustive direction x data, takeover off/on, both unlock levels
      for (int f = 0; f < 2; f++) begin
         wr_fn(f ? 3'b100 : 3'b000);
         for (int l = 0; l < 2; l++) begin
            lock_lost = l[0];
            for (int d = 0; d < 64; d++) begin
               wr_dir(d[5:0]);
               for (int v = 0; v < 64; v++) begin
                  wr_dat(v[5:0]);
                  e = d[5:0] & ~v[5:0];
                  if (f) e[5] = l[0];
                  for (int i = 0; i < 6; i++) begin
                     if (i == 5 && f) check(pad_drv_lo[i] == e[i], "R5 unlock takeover", pad_drv_lo, e);
                     else if (d[i])   check(pad_drv_lo[i] == e[i], "R4 open-drain data", pad_drv_lo, e);
                     else             check(pad_drv_lo[i] == e[i], "R3 input not driven", pad_drv_lo, e);
                  end
               end
            end
         end
      end

      // R6 R7 R8: readback sweep over pads and counter routing
      wr_dir(6'h00);
      prev_raw = {pad_aux_in, pad_io_in};
      for (int f = 0; f < 4; f++) begin
         wr_fn({1'b0, f[1:0]});
         @(negedge clk); @(negedge clk);
         prev_raw = {pad_aux_in, pad_io_in};
         for (int p = 0; p < 256; p++) begin
            pad_io_in = p[5:0]; pad_aux_in = p[7:6];
            #1;
            check(hctr_out == (f[0] & p[6]), "R6 high counter route", hctr_out, f[0] & p[6]);
            check(lctr_out == (f[1] & p[7]), "R7 low counter route", lctr_out, f[1] & p[7]);
            @(negedge clk);
            exp_rd = prev_raw & {~f[1], ~f[0], 6'h3F};
            check(rd_data == exp_rd, "R8 one edge still old", rd_data, exp_rd);
            @(negedge clk);
            exp_rd = p[7:0] & {~f[1], ~f[0], 6'h3F};
            if (f[0] && p[6])      check(rd_data == exp_rd, "R6 masked readback", rd_data, exp_rd);
            else if (f[1] && p[7]) check(rd_data == exp_rd, "R7 masked readback", rd_data, exp_rd);
            else                   check(rd_data == exp_rd, "R8 two-edge readback", rd_data, exp_rd);
            prev_raw = p[7:0];
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule